// File: doc/BRIEF.md
# Legacy BIOS Region Access Steering

This block decides, for every host access into the legacy window between 768 KB and 1 MB, whether the access goes to main memory or to the downstream legacy bus. The window is split into thirteen segments. One segment covers the top 64 KB. The other twelve are 16 KB each and cover C0000h to EFFFFh. Each segment has a read-enable bit and a write-enable bit.

These bits live in seven byte-wide attribute registers. Software writes them through a simple indexed port. A request carries a 20-bit address and a direction bit. The route output is combinational from the request and the current register contents. Reads and writes to the same segment are steered independently, so a segment can be read-only, write-only, read/write or disabled toward memory.

A small lock state machine guards the registers. It has two states, ST_OPEN and ST_SEALED. Reset places it in ST_OPEN. The transition SEAL (ST_OPEN to ST_SEALED) is taken on any clock edge where `lock_set` is high. ST_SEALED holds until reset, and only reset leaves it. Attribute writes are accepted only while the state at the clock edge is ST_OPEN.

Top module: `lbs_steer_top`

## Requirements
- R1: After reset, every register reads 0x00 and every decoded request gives route_mem=0.
- R2: Register 0 bits 5:4 control F0000h–FFFFFh. For k = 1..6, register k bits 1:0 control the 16 KB segment at C0000h + (k-1)·8000h, and bits 5:4 control the 16 KB segment just above it.
- R3: For a read request (req_is_wr=0), route_mem equals the lower bit of the segment's field (bit 0 or bit 4).
- R4: For a write request (req_is_wr=1), route_mem equals the upper bit of the segment's field (bit 1 or bit 5).
- R5: Read and write steering of one segment are independent. All four combinations (none, read-only, write-only, both) are reachable.
- R6: Bits 7:6 and 3:2 of every register, and bits 1:0 of register 0, read as 0 and ignore writes.
- R7: For any address below C0000h, no_match=1 and route_mem=0, whatever the register contents. For decoded addresses, no_match=0.
- R8: Index 7 holds no register. A write to it changes nothing, and a read of it returns 0x00.
- R9: A write is applied only if the lock state is ST_OPEN at that clock edge. A write in the same cycle as lock_set is still applied, and all later writes are ignored.
- R10: ST_SEALED is left only by reset. Dropping lock_set does not reopen the registers.
- R11: A register write captured at a clock edge steers requests from that edge on. A request in the same cycle as the write sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Attribute register write strobe |
| cfg_idx | input | 3 | Register index for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the indexed register (combinational) |
| lock_set | input | 1 | Seals the registers from the next edge on |
| req_addr | input | 20 | Host request address |
| req_is_wr | input | 1 | Request direction: 1 write, 0 read |
| route_mem | output | 1 | 1: claim for main memory, 0: forward to legacy bus |
| no_match | output | 1 | Address outside the decoded window |

## Verification
Requests are issued at the first and last byte of each of the thirteen segments, in both directions, after every register has been given a different pattern. This shows whether the address-to-register and low/high field mapping is correct, including the off-by-one edges of each segment. A single segment is then set to each of the four read/write combinations, which separates read steering from write steering. Addresses below C0000h, with all segments enabled, show that undecoded space never reaches memory. Writes to reserved bits, to the empty index 7, together with lock_set, and after it, show which writes the register bank accepts.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    localparam int ADDR_W   = 20;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 7;
    localparam int IDX_W    = $clog2(NUM_REGS + 1);
    localparam int SEG_LSB  = 14;

    typedef enum logic {
        ST_OPEN,
        ST_SEALED
    } lock_state_e;

    typedef struct packed {
        logic             match;
        logic [IDX_W-1:0] idx;
        logic             hi;
    } seg_sel_t;

    function automatic logic [REG_W-1:0] field_mask(input int idx);
        return (idx == 0) ? 8'h30 : 8'h33;
    endfunction
endpackage

// File: rtl/lbs_lock_fsm.sv
module lbs_lock_fsm
    import lbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_set,
    output logic wr_allow
);
    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (lock_set) state_d = ST_SEALED;
            ST_SEALED: state_d = ST_SEALED;
            default:   state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_OPEN:   wr_allow = 1'b1;
            ST_SEALED: wr_allow = 1'b0;
            default:   wr_allow = 1'b0;
        endcase
    end

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEALED) |=> (state_q == ST_SEALED));
endmodule

// File: rtl/lbs_attr_bank.sv
module lbs_attr_bank
    import lbs_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int RW     = REG_W,
    parameter int IW     = IDX_W
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_allow,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    input  logic [IW-1:0] sel_idx,
    output logic [RW-1:0] sel_byte
);
    logic [N_REGS-1:0][RW-1:0] bank;

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        localparam logic [RW-1:0] MASK = field_mask(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank[g] <= '0;
            else if (wr_allow && cfg_we && (int'(cfg_idx) == g))
                bank[g] <= cfg_wdata & MASK;
        end

        assert_resv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bank[g] & ~MASK) == '0);
    end

    always_comb begin
        cfg_rdata = '0;
        if (int'(cfg_idx) < N_REGS) cfg_rdata = bank[cfg_idx];
    end

    always_comb begin
        sel_byte = '0;
        if (int'(sel_idx) < N_REGS) sel_byte = bank[sel_idx];
    end

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow |=> $stable(bank));
endmodule

// File: rtl/lbs_seg_decode.sv
module lbs_seg_decode
    import lbs_pkg::*;
#(
    parameter int AW = ADDR_W
)(
    input  logic [AW-1:SEG_LSB] addr_hi,
    output seg_sel_t            sel
);
    localparam int TOP = AW - 1;

    always_comb begin
        sel = '0;
        if (addr_hi[TOP -: 4] == 4'hF) begin
            sel.match = 1'b1;
            sel.idx   = '0;
            sel.hi    = 1'b1;
        end else if (addr_hi[TOP -: 2] == 2'b11) begin
            sel.match = 1'b1;
            sel.idx   = IDX_W'(addr_hi[TOP-2 -: 3]) + IDX_W'(1);
            sel.hi    = addr_hi[SEG_LSB];
        end
    end
endmodule

// File: rtl/lbs_steer_top.sv
module lbs_steer_top
    import lbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              lock_set,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_wr,
    output logic              route_mem,
    output logic              no_match
);
    logic             wr_allow;
    seg_sel_t         sel;
    logic [REG_W-1:0] sel_byte;
    logic [1:0]       field;

    lbs_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_set (lock_set),
        .wr_allow (wr_allow)
    );

    lbs_seg_decode #(.AW(ADDR_W)) u_dec (
        .addr_hi (req_addr[ADDR_W-1:SEG_LSB]),
        .sel     (sel)
    );

    lbs_attr_bank #(.N_REGS(NUM_REGS), .RW(REG_W), .IW(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_allow  (wr_allow),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .sel_idx   (sel.idx),
        .sel_byte  (sel_byte)
    );

    assign field     = sel.hi ? sel_byte[5:4] : sel_byte[1:0];
    assign route_mem = sel.match & (req_is_wr ? field[1] : field[0]);
    assign no_match  = ~sel.match;

    assert_nomatch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        no_match |-> !route_mem);
    assert_low_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr < 20'hC0000) |-> no_match);
    assert_high_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr >= 20'hC0000) |-> !no_match);
endmodule

// File: tb/tb_lbs_steer_top.sv
`timescale 1ns/1ps
module tb_lbs_steer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        lock_set = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_is_wr = 1'b0;
    logic        route_mem, no_match;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic  route;
        logic  nm;
        logic [19:0] addr;
        logic  wr;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    logic [7:0] model [7];
    logic       model_lock;

    always #5 clk = ~clk;

    lbs_steer_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lock_set(lock_set),
        .req_addr(req_addr), .req_is_wr(req_is_wr),
        .route_mem(route_mem), .no_match(no_match)
    );

    function automatic logic exp_route(input logic [19:0] a, input logic wr);
        int r, hi, off;
        logic [1:0] f;
        if (a < 20'hC0000) return 1'b0;
        if (a >= 20'hF0000) begin
            r = 0; hi = 1;
        end else begin
            off = (int'(a) - 'hC0000) / 16384;
            r = 1 + off / 2;
            hi = off % 2;
        end
        f = hi ? model[r][5:4] : model[r][1:0];
        return wr ? f[1] : f[0];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 7; i++) model[i] = 8'h00;
        model_lock = 1'b0;
    endtask

    // monitor: pops one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (route_mem !== e.route || no_match !== e.nm) begin
                n_fail++;
                $display("FAIL %s addr=%05h wr=%0b route/nomatch actual=%0b/%0b expected=%0b/%0b",
                         e.tag, e.addr, e.wr, route_mem, no_match, e.route, e.nm);
            end
        end
    end

    // driver: one request per cycle, expected pushed from the model
    task automatic req(input logic [19:0] a, input logic wr, input string tag);
        exp_t e;
        @(posedge clk); #1;
        req_addr = a; req_is_wr = wr;
        e.route = exp_route(a, wr);
        e.nm    = (a < 20'hC0000);
        e.addr  = a; e.wr = wr; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [7:0] d, input logic lk);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d; lock_set = lk;
        @(posedge clk); #1;
        if (!model_lock && idx < 7)
            model[idx] = d & ((idx == 0) ? 8'h30 : 8'h33);
        if (lk) model_lock = 1'b1;
        cfg_we = 1'b0; lock_set = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] idx, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        cfg_idx = idx;
        #2;
        n_checks++;
        if (cfg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s reg%0d actual=%02h expected=%02h", tag, idx, cfg_rdata, exp);
        end
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic sweep(input string tag);
        logic [19:0] base;
        for (int s = 0; s < 13; s++) begin
            base = (s < 12) ? 20'(32'hC0000 + s * 16384) : 20'hF0000;
            for (int w = 0; w < 2; w++) begin
                req(base, w[0], tag);
                req(base + ((s < 12) ? 20'h3FFF : 20'hFFFF), w[0], tag);
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents and routing
        for (int i = 0; i < 7; i++) rd_check(3'(i), 8'h00, "R1 reset value");
        sweep("R1 reset routing");
        drain();

        // R6: reserved bits
        cfg_write(3'd4, 8'hFF, 1'b0);
        rd_check(3'd4, 8'h33, "R6 reserved bits reg4");
        cfg_write(3'd0, 8'hFF, 1'b0);
        rd_check(3'd0, 8'h30, "R6 reserved bits reg0");

        // R3 R4 R5: four combinations on D8000h/DC000h (reg4)
        for (int c = 0; c < 4; c++) begin
            cfg_write(3'd4, 8'(c) | 8'(c << 4), 1'b0);
            req(20'hD8000, 1'b0, "R3 read steer");
            req(20'hD8000, 1'b1, "R4 write steer");
            req(20'hDFFFF, 1'b0, "R5 combo hi read");
            req(20'hDFFFF, 1'b1, "R5 combo hi write");
        end
        cfg_write(3'd4, 8'h21, 1'b0);
        req(20'hD8000, 1'b0, "R5 lo read-only rd");
        req(20'hD8000, 1'b1, "R5 lo read-only wr");
        req(20'hDC000, 1'b0, "R5 hi write-only rd");
        req(20'hDC000, 1'b1, "R5 hi write-only wr");
        drain();

        // R2: distinct pattern per register, full segment sweep
        cfg_write(3'd0, 8'h10, 1'b0);
        cfg_write(3'd1, 8'h12, 1'b0);
        cfg_write(3'd2, 8'h21, 1'b0);
        cfg_write(3'd3, 8'h03, 1'b0);
        cfg_write(3'd4, 8'h30, 1'b0);
        cfg_write(3'd5, 8'h01, 1'b0);
        cfg_write(3'd6, 8'h20, 1'b0);
        sweep("R2 segment map");
        drain();
        cfg_write(3'd0, 8'h20, 1'b0);
        cfg_write(3'd1, 8'h21, 1'b0);
        cfg_write(3'd6, 8'h13, 1'b0);
        sweep("R2 segment map second pattern");
        drain();

        // R7: undecoded space with everything enabled
        for (int i = 0; i < 7; i++) cfg_write(3'(i), 8'hFF, 1'b0);
        req(20'h00000, 1'b0, "R7 no match");
        req(20'hA0000, 1'b1, "R7 no match");
        req(20'hBFFFF, 1'b0, "R7 no match");
        req(20'hBFFFF, 1'b1, "R7 no match");
        req(20'hC0000, 1'b1, "R7 first decoded");
        drain();

        // R8: empty index
        cfg_write(3'd7, 8'hFF, 1'b0);
        rd_check(3'd7, 8'h00, "R8 index 7 read");
        cfg_write(3'd7, 8'h00, 1'b0);
        for (int i = 0; i < 7; i++)
            rd_check(3'(i), (i == 0) ? 8'h30 : 8'h33, "R8 index 7 no effect");

        // R11: same-cycle request sees old value, next cycle sees new
        cfg_write(3'd2, 8'h00, 1'b0);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = 3'd2; cfg_wdata = 8'h01;
        req_addr = 20'hC8000; req_is_wr = 1'b0;
        #3;
        n_checks++;
        if (route_mem !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 same cycle actual=%0b expected=0", route_mem);
        end
        @(posedge clk); #1;
        cfg_we = 1'b0;
        model[2] = 8'h01;
        #3;
        n_checks++;
        if (route_mem !== 1'b1) begin
            n_fail++;
            $display("FAIL R11 next cycle actual=%0b expected=1", route_mem);
        end

        // R9: write with lock_set applies, later writes ignored
        cfg_write(3'd3, 8'h12, 1'b1);
        rd_check(3'd3, 8'h12, "R9 write with lock applied");
        cfg_write(3'd3, 8'h21, 1'b0);
        rd_check(3'd3, 8'h12, "R9 locked write ignored");
        req(20'hD0000, 1'b1, "R9 locked routing");
        req(20'hD0000, 1'b0, "R9 locked routing");
        drain();

        // R10: still sealed after lock_set drops
        repeat (3) @(posedge clk);
        cfg_write(3'd5, 8'h00, 1'b0);
        rd_check(3'd5, 8'h33, "R10 sealed stays");
        req(20'hD8000, 1'b1, "R10 sealed routing");
        drain();

        // R10/R1: reset reopens and clears
        @(posedge clk); #1 rst_n = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        rd_check(3'd3, 8'h00, "R1 cleared after reset");
        cfg_write(3'd3, 8'h02, 1'b0);
        rd_check(3'd3, 8'h02, "R10 reset reopens");
        req(20'hD0000, 1'b1, "R4 after reopen");
        drain();

        summary();
    end
endmodule